// File: doc/BRIEF.md
# Dual-Channel Transmit Frame Buffer

This block sits between a host register interface and the transmit path of a simple Ethernet MAC. It holds two independent frame channels, each with a byte FIFO and a stored frame length. The host selects a channel, fills its FIFO through 32-bit data writes, programs the frame length and then starts the send. The queued bytes then leave on one byte-wide valid/ready stream that carries a last-byte flag and the number of the channel they come from.

When a frame has fully left, its channel is wiped: the FIFO is emptied, the stored length returns to zero and the channel's interrupt status bit is set. A single interrupt line is high whenever an enabled status bit is set. Status bits are cleared by writing ones to them. Only one frame streams at a time. A start on the other channel waits until the current frame has ended. Preamble, CRC and line coding belong to later stages.

All register accesses are single-cycle writes (`reg_we` high for one clock) and take effect at that clock edge.

Top module: `mac_tx_buffer`

## Requirements
- R1: A write to address 2 pushes the 32-bit data into the selected channel's FIFO, least significant byte first. The bytes later stream out in the order they were pushed.
- R2: If fewer than 4 bytes are free in the selected FIFO (capacity 2048 bytes per channel), the whole data write is dropped and the stored bytes are unchanged.
- R3: A write to address 1 selects the channel given by the written value when that value is 0 or 1. Any value of 2 or more selects channel 0.
- R4: A write to address 8 + ch stores the frame length of channel ch. A value above the 2048-byte capacity is stored as 2048.
- R5: A write to address 12 + ch with bit 0 set starts channel ch, but only while bit 0 of the control register (address 0) is 1. Otherwise the start is ignored.
- R6: A started frame sends the smaller of the stored length and the bytes held at the start. `tx_last` is high on exactly the final byte, and `tx_chan` gives the channel number.
- R7: When the send length at start is zero, nothing is streamed and no status bit is set.
- R8: After a frame's last byte is accepted, that channel's FIFO is empty, its length is zero, and status bit ch (bit 0 for channel 0, bit 1 for channel 1) is set.
- R9: `irq` is high exactly when the status register AND the enable register (written at address 3, bit ch per channel) is non-zero.
- R10: A write to address 4 clears each status bit written as 1. If a frame end sets the same bit in the same cycle, the bit ends up set.
- R11: A start on a channel that is already waiting or streaming is ignored.
- R12: A start on one channel while the other streams waits and streams after the current frame ends. Each frame streams whole, on one channel, with no interleaving.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_chan` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_chan | output | 1 | Channel the current frame comes from |
| irq | output | 1 | Masked transmit interrupt |

## Verification
A frame end and a host status-clear write can land on the same clock edge. In that case the set caused by the frame end must win over the clear. The bench provokes this with a one-byte frame held stalled. It then raises `tx_ready` in the same cycle as a clear write for that channel's bit, and judges the result through `irq` with the bit enabled. A follow-up clear on its own must then drop `irq`, which shows the bit was set and not left over from before.

// File: rtl/mac_txb_pkg.sv
// Package: shared register addresses and helpers for the dual-channel transmit buffer.
// Assumes: at most four channels, so the per-channel windows at 8 and 12 do not overlap.
package mac_txb_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_CHSEL    = 4'd1;
    localparam logic [ADDR_W-1:0] A_DATA     = 4'd2;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd3;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_LEN_BASE = 4'd8;
    localparam logic [ADDR_W-1:0] A_GO_BASE  = 4'd12;
endpackage

// File: rtl/mac_txb_fifo.sv
// Module: one channel's byte FIFO. Words of four bytes go in, single bytes come out.
// Assumes: BYTES is a power of two and a multiple of 4. The caller only pushes when
// at least 4 bytes are free and only pops when the FIFO is non-empty. Flush beats push and pop.
module mac_txb_fifo #(
    parameter int BYTES = 2048,
    localparam int WORDS = BYTES / 4,
    localparam int WAW   = $clog2(WORDS),
    localparam int BAW   = $clog2(BYTES),
    localparam int CW    = BAW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [31:0]   push_word,
    input  logic          flush,
    input  logic          pop,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] fill
);
    logic [31:0]    mem [WORDS];
    logic [WAW-1:0] wr_ptr;
    logic [BAW-1:0] rd_ptr;
    logic [CW-1:0]  fill_q;
    logic [31:0]    rd_word;

    // Word storage: write a whole pushed word unless the channel is being flushed.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_word;
        end
    end

    // Pointers and occupancy: flush returns everything to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            fill_q <= fill_q + (push ? CW'(4) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    // Byte view: pick the byte lane of the word under the read pointer.
    always_comb begin
        rd_word = mem[rd_ptr[BAW-1:2]];
        rd_byte = rd_word[8*rd_ptr[1:0] +: 8];
    end

    assign fill = fill_q;
endmodule

// File: rtl/mac_txb_regs.sv
// Module: register decode for the transmit buffer. Holds transmit enable, channel select,
// per-channel lengths, interrupt enable and status. Produces push and start requests.
// Assumes: single-cycle write strobes. A frame end (done) beats host writes to the
// same length or status bit.
module mac_txb_regs
    import mac_txb_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int BYTES = 2048,
    localparam int LEN_W = $clog2(BYTES) + 1,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [31:0]               reg_wdata,
    input  logic [NCH-1:0][LEN_W-1:0] fill,
    input  logic [NCH-1:0]            busy,
    input  logic [NCH-1:0]            done,
    output logic [NCH-1:0]            push,
    output logic [31:0]               push_word,
    output logic [NCH-1:0]            start,
    output logic [NCH-1:0][LEN_W-1:0] start_len,
    output logic [NCH-1:0]            int_stat,
    output logic [NCH-1:0]            int_en,
    output logic                      irq
);
    logic           tx_en;
    logic [CHW-1:0] sel;
    logic           wr_ctrl, wr_sel, wr_data, wr_en, wr_clr;
    logic [LEN_W-1:0] len_in;

    // Fixed address decode.
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == A_CTRL);
        wr_sel  = reg_we && (reg_addr == A_CHSEL);
        wr_data = reg_we && (reg_addr == A_DATA);
        wr_en   = reg_we && (reg_addr == A_IRQ_EN);
        wr_clr  = reg_we && (reg_addr == A_IRQ_CLR);
        len_in  = (reg_wdata > 32'(BYTES)) ? LEN_W'(BYTES) : reg_wdata[LEN_W-1:0];
    end

    // Global transmit enable and channel select; an out-of-range select falls back to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            sel   <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_en <= reg_wdata[0];
            end
            if (wr_sel) begin
                sel <= (reg_wdata < 32'(NCH)) ? reg_wdata[CHW-1:0] : '0;
            end
        end
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en <= '0;
        end else if (wr_en) begin
            int_en <= reg_wdata[NCH-1:0];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [LEN_W-1:0] len_q;
            logic [LEN_W-1:0] send_len;
            logic             wr_len, wr_go;

            // Per-channel decode and send length: the smaller of stored length and occupancy.
            always_comb begin
                wr_len   = reg_we && (reg_addr == ADDR_W'(A_LEN_BASE + c));
                wr_go    = reg_we && (reg_addr == ADDR_W'(A_GO_BASE + c));
                send_len = (len_q < fill[c]) ? len_q : fill[c];
            end

            assign start_len[c] = send_len;
            assign start[c]     = wr_go && reg_wdata[0] && tx_en && !busy[c] && (send_len != '0);
            assign push[c]      = wr_data && (sel == CHW'(c)) && (fill[c] <= LEN_W'(BYTES - 4));

            // Stored frame length: cleared when the channel's frame ends.
            always_ff @(posedge clk) begin
                if (!rst_n || done[c]) begin
                    len_q <= '0;
                end else if (wr_len) begin
                    len_q <= len_in;
                end
            end

            // Status bit: set by frame end, which wins over a same-cycle write-1 clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    int_stat[c] <= 1'b0;
                end else if (done[c]) begin
                    int_stat[c] <= 1'b1;
                end else if (wr_clr && reg_wdata[c]) begin
                    int_stat[c] <= 1'b0;
                end
            end
        end
    endgenerate

    assign push_word = reg_wdata;
    assign irq       = |(int_stat & int_en);
endmodule

// File: rtl/mac_txb_sched.sv
// Module: frame scheduler and byte streamer. Queues started channels, runs one frame at a
// time on the valid/ready output and reports each channel's frame end.
// Assumes: starts arrive only for channels that are neither waiting nor streaming, with a
// non-zero length that does not exceed the channel's occupancy. Lowest index wins a tie.
module mac_txb_sched #(
    parameter int NCH   = 2,
    parameter int BYTES = 2048,
    localparam int LEN_W = $clog2(BYTES) + 1,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            start,
    input  logic [NCH-1:0][LEN_W-1:0] start_len,
    input  logic [NCH-1:0][7:0]       rd_byte,
    input  logic                      tx_ready,
    output logic [NCH-1:0]            pop,
    output logic [NCH-1:0]            done,
    output logic [NCH-1:0]            busy,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    output logic                      tx_last,
    output logic [CHW-1:0]            tx_chan
);
    logic [NCH-1:0]            pending;
    logic [NCH-1:0][LEN_W-1:0] plen;
    logic                      active;
    logic [CHW-1:0]            act_ch;
    logic [LEN_W-1:0]          remain;
    logic                      found, launch, hs, fin;
    logic [CHW-1:0]            pick;

    // Pick the lowest-numbered waiting channel.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (pending[c] && !found) begin
                found = 1'b1;
                pick  = CHW'(c);
            end
        end
        launch = !active && found;
        hs     = active && tx_ready;
        fin    = hs && (remain == LEN_W'(1));
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_pend
            // Waiting flag and latched send length per channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pending[c] <= 1'b0;
                    plen[c]    <= '0;
                end else if (start[c]) begin
                    pending[c] <= 1'b1;
                    plen[c]    <= start_len[c];
                end else if (launch && (pick == CHW'(c))) begin
                    pending[c] <= 1'b0;
                end
            end

            assign pop[c]  = hs && (act_ch == CHW'(c));
            assign done[c] = fin && (act_ch == CHW'(c));
            assign busy[c] = pending[c] || (active && (act_ch == CHW'(c)));
        end
    endgenerate

    // Streaming engine: load a frame when idle, count bytes down on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            act_ch <= '0;
            remain <= '0;
        end else if (launch) begin
            active <= 1'b1;
            act_ch <= pick;
            remain <= plen[pick];
        end else if (hs) begin
            remain <= remain - 1'b1;
            if (fin) begin
                active <= 1'b0;
            end
        end
    end

    assign tx_valid = active;
    assign tx_data  = rd_byte[act_ch];
    assign tx_last  = active && (remain == LEN_W'(1));
    assign tx_chan  = act_ch;
endmodule

// File: rtl/mac_tx_buffer.sv
// Module: top of the dual-channel transmit frame buffer. Joins register decode,
// per-channel FIFOs and the streaming scheduler.
// Assumes: a single clock domain and synchronous active-low reset.
module mac_tx_buffer
    import mac_txb_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int BYTES = 2048,
    localparam int LEN_W = $clog2(BYTES) + 1,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [CHW-1:0]    tx_chan,
    output logic              irq
);
    logic [NCH-1:0][LEN_W-1:0] fill;
    logic [NCH-1:0][LEN_W-1:0] start_len;
    logic [NCH-1:0][7:0]       rd_byte;
    logic [NCH-1:0]            push, start, busy, done, pop;
    logic [31:0]               push_word;
    logic [NCH-1:0]            int_stat, int_en;

    mac_txb_regs #(.NCH(NCH), .BYTES(BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .fill      (fill),
        .busy      (busy),
        .done      (done),
        .push      (push),
        .push_word (push_word),
        .start     (start),
        .start_len (start_len),
        .int_stat  (int_stat),
        .int_en    (int_en),
        .irq       (irq)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_fifo
            mac_txb_fifo #(.BYTES(BYTES)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push[c]),
                .push_word (push_word),
                .flush     (done[c]),
                .pop       (pop[c]),
                .rd_byte   (rd_byte[c]),
                .fill      (fill[c])
            );
        end
    endgenerate

    mac_txb_sched #(.NCH(NCH), .BYTES(BYTES)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_len (start_len),
        .rd_byte   (rd_byte),
        .tx_ready  (tx_ready),
        .pop       (pop),
        .done      (done),
        .busy      (busy),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_chan   (tx_chan)
    );
endmodule

// File: rtl/mac_tx_buffer_chk.sv
// Module: protocol and status checks for the transmit buffer, bound to the top module.
// Assumes: observes the top's ports plus its interrupt status and enable registers.
module mac_tx_buffer_chk
    import mac_txb_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic [CHW-1:0]    tx_chan,
    input logic              irq,
    input logic [NCH-1:0]    stat_q,
    input logic [NCH-1:0]    en_q
);
    // R13: a stalled byte holds its data, flag and channel.
    a_r13_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_chan)));

    // R8: the last accepted byte sets that channel's status bit.
    a_r8_end_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> stat_q[$past(tx_chan)]);

    // R10: a clear write with no frame end leaves the written bits at zero.
    a_r10_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == A_IRQ_CLR) && !(tx_valid && tx_ready && tx_last))
        |=> ((stat_q & $past(reg_wdata[NCH-1:0])) == '0));

    // R9: the interrupt needs both some status and some enable.
    a_r9_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat_q != '0) && (en_q != '0)));

    // R12: an accepted non-final byte is followed by more of the same frame.
    a_r12_frame_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_last) |=> (tx_valid && $stable(tx_chan)));
endmodule

bind mac_tx_buffer mac_tx_buffer_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_chan   (tx_chan),
    .irq       (irq),
    .stat_q    (int_stat),
    .en_q      (int_en)
);

// File: tb/mac_tx_buffer_tb.sv
// Bench: directed corner cases plus seeded random frames, checked against a bench-side model.
module mac_tx_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_ready = 1'b0;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic [0:0]  tx_chan;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bench model: word storage, byte counts, lengths, status, enable, select, tx enable.
    logic [31:0] mq [2][512];
    int          mcnt [2];
    int          mlen [2];
    logic [1:0]  mstat = '0;
    logic [1:0]  men = '0;
    int          msel = 0;
    bit          mtxen = 0;

    always #4 clk = ~clk;

    mac_tx_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .tx_chan(tx_chan), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [7:0] mbyte(input int ch, input int i);
        logic [31:0] w;
        w = mq[ch][i / 4];
        return w[8 * (i % 4) +: 8];
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        wr(4'd2, w);
        if (mcnt[msel] <= 2044) begin
            mq[msel][mcnt[msel] / 4] = w;
            mcnt[msel] += 4;
        end
    endtask

    task automatic setsel(input int v);
        wr(4'd1, 32'(v));
        msel = (v < 2) ? v : 0;
    endtask

    task automatic setlen(input int ch, input int v);
        wr(4'(8 + ch), 32'(v));
        mlen[ch] = (v > 2048) ? 2048 : v;
    endtask

    task automatic seten(input logic [1:0] v);
        wr(4'd3, {30'd0, v});
        men = v;
    endtask

    task automatic clrstat(input logic [1:0] v);
        wr(4'd4, {30'd0, v});
        mstat = mstat & ~v;
    endtask

    task automatic chk_irq(input string tag);
        chk(irq === ((mstat & men) != 2'b00), tag, "irq", int'(irq), int'((mstat & men) != 2'b00));
    endtask

    task automatic expect_idle(input int n, input string tag);
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (tx_valid) seen = 1;
        end
        chk(!seen, tag, "tx_valid while idle", int'(seen), 0);
    endtask

    // Collect one frame from channel ch of n bytes; rnd selects random back-pressure.
    task automatic collect(input int ch, input int n, input string tag, input bit rnd);
        int idx = 0;
        int waited = 0;
        bit bad_data = 0, bad_last = 0, bad_chan = 0, bad_hold = 0, held = 0;
        logic [7:0] hold_d = '0;
        int act_b = 0, exp_b = 0;
        while (idx < n && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (held && (tx_data !== hold_d)) bad_hold = 1;
            tx_ready = rnd ? (($urandom % 4) != 0) : 1'b1;
            if (tx_valid && tx_ready) begin
                if (tx_data !== mbyte(ch, idx) && !bad_data) begin
                    bad_data = 1; act_b = int'(tx_data); exp_b = int'(mbyte(ch, idx));
                end
                if (tx_last !== (idx == n - 1)) bad_last = 1;
                if (tx_chan !== ch[0]) bad_chan = 1;
                idx++;
                held = 0;
            end else if (tx_valid) begin
                held = 1; hold_d = tx_data;
            end else begin
                held = 0;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(idx == n, tag, "bytes streamed", idx, n);
        chk(!bad_data, tag, "byte value", act_b, exp_b);
        chk(!bad_last, "R6", "tx_last placement", int'(bad_last), 0);
        chk(!bad_chan, "R12", "tx_chan", int'(bad_chan), 0);
        chk(!bad_hold, "R13", "stalled data stable", int'(bad_hold), 0);
        mcnt[ch] = 0; mlen[ch] = 0; mstat[ch] = 1'b1;
    endtask

    task automatic go(input int ch, input string tag);
        int n;
        n = (mlen[ch] < mcnt[ch]) ? mlen[ch] : mcnt[ch];
        wr(4'(12 + ch), 32'd1);
        if (mtxen && n > 0) collect(ch, n, tag, 1'b1);
        else expect_idle(6, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        mcnt[0] = 0; mcnt[1] = 0; mlen[0] = 0; mlen[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid === 1'b0, "R6", "reset tx_valid", int'(tx_valid), 0);
        chk(irq === 1'b0, "R9", "reset irq", int'(irq), 0);

        // R5: start with transmit disabled is ignored.
        push(32'h0403_0201);
        setlen(0, 4);
        go(0, "R5");
        wr(4'd0, 32'd1); mtxen = 1;
        go(0, "R5");

        // R1: byte order across two words, partial length.
        push(32'h0403_0201); push(32'h0807_0605);
        setlen(0, 6);
        go(0, "R1");
        push(32'hA3A2_A1A0);   // leftover 2 bytes were flushed by the previous send (R8)
        setlen(0, 4);
        go(0, "R8");

        // R3: out-of-range select falls back to channel 0.
        setsel(1); setsel(2);
        push(32'hB3B2_B1B0);
        setlen(0, 4);
        go(0, "R3");
        setsel(1);
        push(32'hC3C2_C1C0);
        setlen(1, 4);
        go(1, "R3");

        // R2 and R4: fill channel 1 beyond capacity, clamp the length.
        setsel(1);
        for (int i = 0; i < 513; i++) push((i == 512) ? 32'hDEAD_BEEF : {8'(i), 8'(i >> 8), 8'(~i), 8'(i + 3)});
        chk(mcnt[1] == 2048, "R2", "model fill", mcnt[1], 2048);
        setlen(1, 4000);
        chk(mlen[1] == 2048, "R4", "model clamp", mlen[1], 2048);
        go(1, "R2");

        // R7: zero send length, both by zero length and by an empty FIFO.
        clrstat(2'b11); seten(2'b11);
        setsel(0); push(32'h1122_3344);
        setlen(0, 0);
        go(0, "R7");
        setlen(1, 5);
        go(1, "R7");
        chk_irq("R7");

        // R8: partial send then length is cleared.
        push(32'h5566_7788);
        setlen(0, 3);
        go(0, "R8");
        push(32'h99AA_BBCC);
        go(0, "R8");
        setlen(0, 4);
        go(0, "R8");
        chk_irq("R8");

        // R11 and R12: start channel 1, hold it stalled, start channel 0, repeat starts.
        clrstat(2'b11);
        setsel(1); push(32'h1111_2222); push(32'h3333_4444); setlen(1, 8);
        setsel(0); push(32'h5555_6666); push(32'h7777_8888); setlen(0, 8);
        wr(4'd13, 32'd1);
        wr(4'd12, 32'd1);
        wr(4'd13, 32'd1);
        wr(4'd12, 32'd1);
        chk(tx_valid && tx_chan == 1'b1, "R12", "channel 1 first", int'(tx_chan), 1);
        collect(1, 8, "R12", 1'b1);
        collect(0, 8, "R12", 1'b1);
        expect_idle(12, "R11");

        // R10: frame end and clear write in the same cycle; set wins.
        clrstat(2'b11); seten(2'b01);
        push(32'h0000_00E7); setlen(0, 1);
        wr(4'd12, 32'd1);
        @(negedge clk);
        chk(tx_valid && tx_last, "R10", "stalled one-byte frame", int'(tx_last), 1);
        tx_ready = 1'b1; reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
        @(negedge clk);
        tx_ready = 1'b0; reg_we = 1'b0;
        mcnt[0] = 0; mlen[0] = 0; mstat[0] = 1'b1;
        chk(irq === 1'b1, "R10", "set wins over clear", int'(irq), 1);
        clrstat(2'b01);
        chk(irq === 1'b0, "R10", "clear alone", int'(irq), 0);

        // R9: masking of status by enable.
        push(32'h0000_00F1); setlen(0, 1);
        go(0, "R9");
        seten(2'b00); chk_irq("R9");
        seten(2'b10); chk_irq("R9");
        seten(2'b01); chk_irq("R9");
        clrstat(2'b11); chk_irq("R9");

        // Random frames with random select, length and back-pressure.
        seten(2'b11);
        for (int it = 0; it < 40; it++) begin
            int ch, nw, ln;
            ch = $urandom % 2;
            setsel((ch == 0 && ($urandom % 2) == 1) ? 2 + ($urandom % 6) : ch);
            nw = $urandom % 12;
            for (int k = 0; k < nw; k++) push($urandom);
            ln = (($urandom % 8) == 0) ? 3000 + ($urandom % 100) : $urandom % 60;
            setlen(ch, ln);
            go(ch, "R6");
            chk_irq("R9");
            clrstat(2'($urandom % 4));
            chk_irq("R10");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule